// File: doc/BRIEF.md
# Lithium Battery Charge Sequencer

This block is the digital sequencer for a single-cell lithium charger. It watches two 10-bit ADC codes, one for the battery voltage and one for the measured charge current, and an input that says whether the wall adaptor is present. From these it chooses one of several charging phases. For each phase it drives a current setpoint code and a voltage-regulation enable to the analog charger. The analog loops that act on the setpoint are outside the block.

The capacity unit C is a configuration input given in current LSBs (1 LSB = 1 mA by default). Every voltage threshold, the hysteresis, the number of consecutive samples that must agree before a phase change, and the two safety time limits are also configuration inputs. A deeply flat cell is first revived at a small fixed current. It then receives a fraction of C until it reaches the fast-charge threshold. Fast charge follows at C/2, capped at 250 mA. At the float voltage the charger holds the voltage and waits for the current to fall. After termination the block watches for the cell to sag and then tops it up.

Top module: `chg_ctrl`

## Requirements
- R1: While `rst` is high, and on the clock edge after `adp_present` is seen low in any mode including fault, the mode becomes idle (code 0). In idle, `iset_code`, `cv_enable`, `chg_done` and `chg_fault` are all 0.
- R2: In idle with the adaptor present, the first valid sample picks the entry mode at once. Below `cfg_v_revive` gives revive. Below `cfg_v_fast` gives precharge. Below `cfg_v_float` gives constant current. Otherwise it gives constant voltage.
- R3: Revive (code 1) drives the fixed setpoint 2. It moves to precharge once qualified samples show vbat >= `cfg_v_revive` + `cfg_hyst`.
- R4: Precharge (code 2) drives C/10. It moves to constant current once qualified samples show vbat >= `cfg_v_fast` + `cfg_hyst`.
- R5: Constant current (code 3) drives min(C/2, 250). It moves to constant voltage once qualified samples show vbat >= `cfg_v_float`.
- R6: Constant voltage (code 4) raises `cv_enable` and keeps the fast-charge setpoint. It terminates once qualified samples show ibat <= (fast-charge setpoint)/10. Done (code 5) drives setpoint 0, `cv_enable` 0 and `chg_done` 1.
- R7: From done, qualified samples with vbat < `cfg_v_resume` - `cfg_hyst` enter recharge (code 6). Recharge drives min(C/4, 250) with `cv_enable` 0. It returns to constant voltage once qualified samples show vbat >= `cfg_v_float`.
- R8: A change needs `cfg_qual_n` consecutive valid samples that meet the condition, and a value of 0 counts as 1. A valid sample that does not meet the condition restarts the count. Cycles with `smp_valid` low neither add to the count nor restart it.
- R9: If precharge or constant current has been held for more than its limit (`cfg_pre_tmo` / `cfg_cc_tmo` clock cycles after entry), fault (code 7) is entered. Fault drives setpoint 0 and `chg_fault` 1, and it stays until the adaptor is removed. An expiry wins over a promotion in the same cycle.
- R10: No setpoint ever exceeds 250. The setpoint and flags change on the same clock edge as `chg_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adp_present | input | 1 | Adaptor present |
| smp_valid | input | 1 | New ADC sample pair this cycle |
| vbat_code | input | 10 | Battery voltage ADC code |
| ibat_code | input | 10 | Charge current ADC code |
| cfg_cap | input | 10 | Capacity unit C in current LSBs |
| cfg_v_revive | input | 10 | Revive/precharge voltage boundary |
| cfg_v_fast | input | 10 | Precharge/fast-charge voltage boundary |
| cfg_v_float | input | 10 | Float voltage code |
| cfg_v_resume | input | 10 | Recharge voltage threshold |
| cfg_hyst | input | 4 | Hysteresis in voltage LSBs |
| cfg_qual_n | input | 4 | Consecutive samples needed |
| cfg_pre_tmo | input | 16 | Precharge limit in cycles |
| cfg_cc_tmo | input | 16 | Constant-current limit in cycles |
| chg_mode | output | 3 | Current mode code |
| iset_code | output | 10 | Current setpoint code |
| cv_enable | output | 1 | Voltage regulation enable |
| chg_done | output | 1 | Charging terminated |
| chg_fault | output | 1 | Safety timer fault |

## Verification
The safety timer and the sample qualifier can both decide in the same clock cycle. For example, the last qualifying precharge sample can arrive on the very edge where the precharge limit runs out. The bench sets a short limit, enters precharge and supplies exactly the required number of qualifying samples so that both events meet. It expects fault, never constant current. Adaptor removal landing on a qualifying sample is also mixed in by the random phase, and a bench reference model judges every cycle.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    MD_IDLE   = 3'd0,
    MD_REVIVE = 3'd1,
    MD_PRE    = 3'd2,
    MD_CC     = 3'd3,
    MD_CV     = 3'd4,
    MD_DONE   = 3'd5,
    MD_RECHG  = 3'd6,
    MD_FAULT  = 3'd7
  } chg_mode_e;
endpackage

// File: rtl/chg_qual.sv
// Consecutive-sample qualifier shared by all mode transitions.
module chg_qual #(
  parameter int DEB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             cond,
  input  logic             clear,
  input  logic [DEB_W-1:0] need_n,
  output logic             fire
);
  logic [DEB_W-1:0] cnt_q;
  logic [DEB_W:0]   n_eff;
  logic [DEB_W:0]   cnt_inc;

  assign n_eff   = (need_n == '0) ? (DEB_W+1)'(1) : {1'b0, need_n};
  assign cnt_inc = {1'b0, cnt_q} + (DEB_W+1)'(1);
  assign fire    = valid && cond && (cnt_inc >= n_eff);

  always_ff @(posedge clk) begin
    if (rst || clear)      cnt_q <= '0;
    else if (valid) begin
      if (!cond || fire)   cnt_q <= '0;
      else                 cnt_q <= cnt_inc[DEB_W-1:0];
    end
  end

  // R8: cycles without a sample leave the count untouched
  p_hold_without_sample_r8: assert property (@(posedge clk) disable iff (rst)
    (!valid && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/chg_timer.sv
// Per-mode safety timer: counts cycles spent in a timed mode.
module chg_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic [TMR_W-1:0] limit,
  output logic             expired
);
  logic [TMR_W-1:0] tmr_q;

  assign expired = run && (tmr_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) tmr_q <= '0;
    else if (tmr_q != '1)     tmr_q <= tmr_q + TMR_W'(1);
  end

  // R9: the count advances by one per cycle while the timed mode lasts
  p_timer_steps_r9: assert property (@(posedge clk) disable iff (rst)
    (run && !clear && tmr_q != '1) |=> (tmr_q == $past(tmr_q) + TMR_W'(1)));
endmodule

// File: rtl/chg_setpoint.sv
// Registered setpoint and flag outputs, computed from the next mode.
module chg_setpoint
  import chg_pkg::*;
#(
  parameter int ADC_W       = 10,
  parameter int REVIVE_CODE = 2,
  parameter int IMAX_CODE   = 250
) (
  input  logic             clk,
  input  logic             rst,
  input  chg_mode_e        mode_nxt,
  input  logic [ADC_W-1:0] cap,
  output logic [ADC_W-1:0] iset,
  output logic             cv_en,
  output logic             done,
  output logic             fault,
  output logic [ADC_W-1:0] term
);
  localparam logic [ADC_W-1:0] IMAX_C = ADC_W'(IMAX_CODE);
  localparam logic [ADC_W-1:0] REV_C  = ADC_W'(REVIVE_CODE);

  function automatic logic [ADC_W-1:0] clip(input logic [ADC_W-1:0] x);
    return (x > IMAX_C) ? IMAX_C : x;
  endfunction

  logic [ADC_W-1:0] fast, pre_i, rch_i, iset_d;

  assign fast  = clip(cap >> 1);
  assign pre_i = clip(cap / ADC_W'(10));
  assign rch_i = clip(cap >> 2);
  assign term  = fast / ADC_W'(10);

  always_comb begin
    case (mode_nxt)
      MD_REVIVE: iset_d = clip(REV_C);
      MD_PRE:    iset_d = pre_i;
      MD_CC,
      MD_CV:     iset_d = fast;
      MD_RECHG:  iset_d = rch_i;
      default:   iset_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iset  <= '0;
      cv_en <= 1'b0;
      done  <= 1'b0;
      fault <= 1'b0;
    end else begin
      iset  <= iset_d;
      cv_en <= (mode_nxt == MD_CV);
      done  <= (mode_nxt == MD_DONE);
      fault <= (mode_nxt == MD_FAULT);
    end
  end

  // R10: setpoint ceiling
  p_iset_ceiling_r10: assert property (@(posedge clk) disable iff (rst)
    iset <= IMAX_C);
  // R6: termination state is quiet
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (iset == '0 && !cv_en && !fault));
endmodule

// File: rtl/chg_ctrl.sv
// Charge sequencer top: mode register and transition selection.
module chg_ctrl
  import chg_pkg::*;
#(
  parameter int ADC_W       = 10,
  parameter int HYS_W       = 4,
  parameter int DEB_W       = 4,
  parameter int TMR_W       = 16,
  parameter int REVIVE_CODE = 2,
  parameter int IMAX_CODE   = 250
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adp_present,
  input  logic             smp_valid,
  input  logic [ADC_W-1:0] vbat_code,
  input  logic [ADC_W-1:0] ibat_code,
  input  logic [ADC_W-1:0] cfg_cap,
  input  logic [ADC_W-1:0] cfg_v_revive,
  input  logic [ADC_W-1:0] cfg_v_fast,
  input  logic [ADC_W-1:0] cfg_v_float,
  input  logic [ADC_W-1:0] cfg_v_resume,
  input  logic [HYS_W-1:0] cfg_hyst,
  input  logic [DEB_W-1:0] cfg_qual_n,
  input  logic [TMR_W-1:0] cfg_pre_tmo,
  input  logic [TMR_W-1:0] cfg_cc_tmo,
  output logic [2:0]       chg_mode,
  output logic [ADC_W-1:0] iset_code,
  output logic             cv_enable,
  output logic             chg_done,
  output logic             chg_fault
);
  localparam int CMP_W = ADC_W + 1;

  chg_mode_e        mode_q, mode_nxt;
  logic             cond, fire, expired, timed, changed;
  logic [ADC_W-1:0] term;
  logic [TMR_W-1:0] limit;
  logic [CMP_W-1:0] vb_x, rev_up, fast_up, hyst_x;

  assign vb_x    = {1'b0, vbat_code};
  assign hyst_x  = CMP_W'(cfg_hyst);
  assign rev_up  = {1'b0, cfg_v_revive} + hyst_x;
  assign fast_up = {1'b0, cfg_v_fast} + hyst_x;

  always_comb begin
    case (mode_q)
      MD_REVIVE: cond = (vb_x >= rev_up);
      MD_PRE:    cond = (vb_x >= fast_up);
      MD_CC,
      MD_RECHG:  cond = (vbat_code >= cfg_v_float);
      MD_CV:     cond = (ibat_code <= term);
      MD_DONE:   cond = ({1'b0, cfg_v_resume} > hyst_x) &&
                        (vb_x < ({1'b0, cfg_v_resume} - hyst_x));
      default:   cond = 1'b0;
    endcase
  end

  assign timed = (mode_q == MD_PRE) || (mode_q == MD_CC);
  assign limit = (mode_q == MD_PRE) ? cfg_pre_tmo : cfg_cc_tmo;

  always_comb begin
    mode_nxt = mode_q;
    if (!adp_present) mode_nxt = MD_IDLE;
    else begin
      case (mode_q)
        MD_IDLE:
          if (smp_valid) begin
            if (vbat_code < cfg_v_revive)     mode_nxt = MD_REVIVE;
            else if (vbat_code < cfg_v_fast)  mode_nxt = MD_PRE;
            else if (vbat_code < cfg_v_float) mode_nxt = MD_CC;
            else                              mode_nxt = MD_CV;
          end
        MD_REVIVE: if (fire) mode_nxt = MD_PRE;
        MD_PRE:    if (expired) mode_nxt = MD_FAULT;
                   else if (fire) mode_nxt = MD_CC;
        MD_CC:     if (expired) mode_nxt = MD_FAULT;
                   else if (fire) mode_nxt = MD_CV;
        MD_CV:     if (fire) mode_nxt = MD_DONE;
        MD_DONE:   if (fire) mode_nxt = MD_RECHG;
        MD_RECHG:  if (fire) mode_nxt = MD_CV;
        default:   mode_nxt = MD_FAULT;
      endcase
    end
  end

  assign changed = (mode_nxt != mode_q);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MD_IDLE;
    else     mode_q <= mode_nxt;
  end

  chg_qual #(.DEB_W(DEB_W)) u_qual (
    .clk(clk), .rst(rst), .valid(smp_valid), .cond(cond),
    .clear(changed), .need_n(cfg_qual_n), .fire(fire)
  );

  chg_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .run(timed), .clear(changed),
    .limit(limit), .expired(expired)
  );

  chg_setpoint #(.ADC_W(ADC_W), .REVIVE_CODE(REVIVE_CODE), .IMAX_CODE(IMAX_CODE)) u_sp (
    .clk(clk), .rst(rst), .mode_nxt(mode_nxt), .cap(cfg_cap),
    .iset(iset_code), .cv_en(cv_enable), .done(chg_done),
    .fault(chg_fault), .term(term)
  );

  assign chg_mode = mode_q;

  // R1: adaptor loss forces idle on the next edge
  p_idle_on_removal_r1: assert property (@(posedge clk) disable iff (rst)
    !adp_present |=> (mode_q == MD_IDLE));
  // R9: fault holds while the adaptor stays
  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_FAULT && adp_present) |=> (mode_q == MD_FAULT));
  // R9: fault is only reached from a timed mode
  p_fault_origin_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_FAULT && $past(mode_q) != MD_FAULT) |->
      ($past(mode_q) == MD_PRE || $past(mode_q) == MD_CC));
  // R6: regulation enable tracks the mode register
  p_cv_alignment_r6: assert property (@(posedge clk) disable iff (rst)
    cv_enable == (mode_q == MD_CV));
  // R3: revive uses its fixed setpoint and never skips precharge
  p_revive_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_REVIVE) |-> (iset_code == ADC_W'(REVIVE_CODE)));
  p_revive_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_REVIVE) |=>
      (mode_q == MD_REVIVE || mode_q == MD_PRE || mode_q == MD_IDLE));
endmodule

// File: tb/tb_chg_ctrl.sv
module tb_chg_ctrl;
  import chg_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adp_present = 1'b0, smp_valid = 1'b0;
  logic [9:0] vbat_code = '0, ibat_code = '0;
  logic [9:0] cfg_cap, cfg_v_revive, cfg_v_fast, cfg_v_float, cfg_v_resume;
  logic [3:0] cfg_hyst, cfg_qual_n;
  logic [15:0] cfg_pre_tmo, cfg_cc_tmo;
  logic [2:0] chg_mode;
  logic [9:0] iset_code;
  logic cv_enable, chg_done, chg_fault;

  int n_checks = 0, n_errs = 0;
  bit finished = 0;
  int m_mode = 0, m_cnt = 0, m_tmr = 0;

  always #10 clk = ~clk;

  chg_ctrl dut (
    .clk(clk), .rst(rst), .adp_present(adp_present), .smp_valid(smp_valid),
    .vbat_code(vbat_code), .ibat_code(ibat_code), .cfg_cap(cfg_cap),
    .cfg_v_revive(cfg_v_revive), .cfg_v_fast(cfg_v_fast),
    .cfg_v_float(cfg_v_float), .cfg_v_resume(cfg_v_resume),
    .cfg_hyst(cfg_hyst), .cfg_qual_n(cfg_qual_n),
    .cfg_pre_tmo(cfg_pre_tmo), .cfg_cc_tmo(cfg_cc_tmo),
    .chg_mode(chg_mode), .iset_code(iset_code), .cv_enable(cv_enable),
    .chg_done(chg_done), .chg_fault(chg_fault)
  );

  function automatic int lim(input int x);
    return (x > 250) ? 250 : x;
  endfunction

  function automatic int fast_i();
    return lim(int'(cfg_cap) / 2);
  endfunction

  // Expected setpoint per mode (R3 R4 R5 R6 R7 R10)
  function automatic int exp_iset(input int md);
    case (md)
      1: return lim(2);
      2: return lim(int'(cfg_cap) / 10);
      3, 4: return fast_i();
      6: return lim(int'(cfg_cap) / 4);
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input int md);
    case (md)
      0: return "R1"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R6"; 6: return "R7"; default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model advance for one clock edge (R2 R8 R9)
  task automatic model_step(input bit adp, input bit vld, input int v, input int i);
    int n, nxt; bit cond, fire, expd, timed;
    n = (cfg_qual_n == 0) ? 1 : int'(cfg_qual_n);
    timed = (m_mode == 2 || m_mode == 3);
    case (m_mode)
      1: cond = v >= int'(cfg_v_revive) + int'(cfg_hyst);
      2: cond = v >= int'(cfg_v_fast) + int'(cfg_hyst);
      3, 6: cond = v >= int'(cfg_v_float);
      4: cond = i <= fast_i() / 10;
      5: cond = v < int'(cfg_v_resume) - int'(cfg_hyst);
      default: cond = 0;
    endcase
    fire = vld && cond && (m_cnt + 1 >= n);
    expd = timed && (m_tmr >= (m_mode == 2 ? int'(cfg_pre_tmo) : int'(cfg_cc_tmo)));
    nxt = m_mode;
    if (!adp) nxt = 0;
    else case (m_mode)
      0: if (vld) nxt = (v < int'(cfg_v_revive)) ? 1 : (v < int'(cfg_v_fast)) ? 2 :
                        (v < int'(cfg_v_float)) ? 3 : 4;
      1: if (fire) nxt = 2;
      2: nxt = expd ? 7 : fire ? 3 : 2;
      3: nxt = expd ? 7 : fire ? 4 : 3;
      4: if (fire) nxt = 5;
      5: if (fire) nxt = 6;
      6: if (fire) nxt = 4;
      default: nxt = 7;
    endcase
    if (nxt != m_mode) begin m_cnt = 0; m_tmr = 0; end
    else begin
      if (vld) m_cnt = cond ? m_cnt + 1 : 0;
      m_tmr = timed ? m_tmr + 1 : 0;
    end
    m_mode = nxt;
  endtask

  task automatic cmp_model(input string tag);
    string r;
    r = (tag == "") ? req_of(m_mode) : tag;
    chk(chg_mode == 3'(m_mode) && iset_code == 10'(exp_iset(m_mode)) &&
        cv_enable == (m_mode == 4) && chg_done == (m_mode == 5) &&
        chg_fault == (m_mode == 7), r,
        int'(chg_mode) * 1000 + int'(iset_code), m_mode * 1000 + exp_iset(m_mode));
  endtask

  task automatic tick(input bit adp, input bit vld, input int v, input int i, input string tag = "");
    adp_present = adp; smp_valid = vld; vbat_code = 10'(v); ibat_code = 10'(i);
    model_step(adp, vld, v, i);
    @(negedge clk);
    cmp_model(tag);
  endtask

  task automatic expect_mode(input int md, input string req);
    chk(chg_mode == 3'(md), req, int'(chg_mode), md);
  endtask

  task automatic set_cfg(input int cap, input int qn, input int pre_t, input int cc_t);
    cfg_cap = 10'(cap); cfg_qual_n = 4'(qn);
    cfg_pre_tmo = 16'(pre_t); cfg_cc_tmo = 16'(cc_t);
    cfg_v_revive = 10'd250; cfg_v_fast = 10'd300; cfg_v_float = 10'd420;
    cfg_v_resume = 10'd410; cfg_hyst = 4'd2;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_c4a6);
    set_cfg(400, 3, 1000, 1000);
    repeat (3) @(negedge clk);
    // R1 reset state, R10 codes
    chk(chg_mode == 3'd0 && iset_code == 0 && !cv_enable && !chg_done && !chg_fault,
        "R1", int'(chg_mode), 0);
    rst = 1'b0;
    tick(1, 0, 0, 0, "R1");
    // R2 entry into revive
    tick(1, 1, 200, 0, "R2");      expect_mode(1, "R2");
    chk(iset_code == 10'd2, "R3", int'(iset_code), 2);
    // R8 qualification: 251 below 252, reset by a miss, invalid cycles ignored
    tick(1, 1, 251, 0, "R8"); tick(1, 1, 252, 0, "R8"); tick(1, 1, 252, 0, "R8");
    tick(1, 1, 240, 0, "R8");
    tick(1, 1, 252, 0, "R8"); tick(1, 0, 100, 0, "R8"); tick(1, 1, 253, 0, "R8");
    expect_mode(1, "R8");
    tick(1, 1, 260, 0, "R3");      expect_mode(2, "R3");
    chk(iset_code == 10'd40, "R4", int'(iset_code), 40);
    repeat (3) tick(1, 1, 302, 0, "R4");
    expect_mode(3, "R4");
    chk(iset_code == 10'd200, "R5", int'(iset_code), 200);
    repeat (2) tick(1, 1, 420, 0, "R5");
    tick(1, 1, 419, 0, "R5");
    repeat (3) tick(1, 1, 420, 0, "R5");
    expect_mode(4, "R5");
    chk(cv_enable, "R6", int'(cv_enable), 1);
    repeat (3) tick(1, 1, 420, 21, "R6");
    repeat (3) tick(1, 1, 420, 20, "R6");
    expect_mode(5, "R6");
    chk(chg_done && iset_code == 0, "R6", int'(iset_code), 0);
    repeat (4) tick(1, 1, 408, 0, "R7");
    expect_mode(5, "R7");
    repeat (3) tick(1, 1, 407, 0, "R7");
    expect_mode(6, "R7");
    chk(iset_code == 10'd100 && !cv_enable, "R7", int'(iset_code), 100);
    repeat (3) tick(1, 1, 425, 0, "R7");
    expect_mode(4, "R7");
    tick(0, 1, 425, 0, "R1");      expect_mode(0, "R1");
    // R10 cap on fast and recharge currents with C = 1020
    set_cfg(1020, 1, 1000, 1000);
    tick(1, 1, 350, 0, "R10");
    chk(iset_code == 10'd250, "R10", int'(iset_code), 250);
    tick(1, 1, 430, 0, "R10");
    tick(1, 1, 430, 25, "R6");     expect_mode(5, "R6");
    tick(1, 1, 400, 0, "R10");     expect_mode(6, "R10");
    chk(iset_code == 10'd250, "R10", int'(iset_code), 250);
    // R8 qual_n of 0 acts as 1
    tick(0, 0, 0, 0, "R1"); cfg_qual_n = 4'd0;
    tick(1, 1, 200, 0, "R2"); tick(1, 1, 252, 0, "R8");
    expect_mode(2, "R8");
    // R9 timeout in precharge, sticky, cleared by removal
    tick(0, 0, 0, 0, "R1"); set_cfg(400, 3, 5, 1000);
    tick(1, 1, 280, 0, "R9");
    repeat (6) tick(1, 0, 280, 0, "R9");
    expect_mode(7, "R9");
    chk(chg_fault && iset_code == 0, "R9", int'(iset_code), 0);
    repeat (3) tick(1, 1, 350, 0, "R9");
    expect_mode(7, "R9");
    tick(0, 0, 0, 0, "R1");        expect_mode(0, "R1");
    // R9 collision: expiry and third qualifying sample on the same edge
    set_cfg(400, 3, 2, 1000);
    tick(1, 1, 280, 0, "R9");
    repeat (3) tick(1, 1, 305, 0, "R9");
    expect_mode(7, "R9");
    tick(0, 0, 0, 0, "R1");
    // Random phases against the model
    for (int ph = 0; ph < 2; ph++) begin
      set_cfg(ph == 0 ? 400 : 700, ph == 0 ? 2 : 3, 40 + ph * 30, 60);
      for (int k = 0; k < 4000; k++) begin
        int v, i; bit adp, vld;
        adp = ($urandom_range(0, 99) != 0);
        vld = ($urandom_range(0, 3) != 0);
        case ($urandom_range(0, 5))
          0: v = $urandom_range(230, 260);
          1: v = $urandom_range(290, 310);
          2: v = $urandom_range(400, 430);
          3: v = $urandom_range(0, 1023);
          default: v = (m_mode < 3) ? $urandom_range(m_mode * 50 + 240, 320) : $urandom_range(404, 424);
        endcase
        i = $urandom_range(0, 40);
        tick(adp, vld, v, i);
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule